// File: doc/BRIEF.md
# DMA Channel Transfer Sequencer

This block runs the data-moving half of a four-channel DMA controller. It holds the working copy of each channel's address, count, page and mode, keeps pending, software-request and terminal-count flags, and moves one unit per clock while the system bus is granted. In each granted cycle the highest-priority channel that needs service is chosen. Its physical address is formed from the page bits and the current address, and a memory strobe is issued with a direction flag. The address and count then step, and terminal count and auto-initialise are applied.

The same RTL serves as a byte-wide primary controller or as a word-wide secondary controller, chosen by parameters. The register interface programs a channel through a load port and reads the current address and count back through a select port. It also supplies the mask bits and the pulse that clears the terminal-count flags. The last data byte seen on a strobed unit is kept in a temporary register.

Top module: `dma_xfer_seq`

## Requirements
- R1: A channel needs service when its request flag is set, or when its pending flag is set and `mask_i` for that channel is 0. A `dreq_i` pulse sets the pending flag and a `sw_req_i` pulse sets the request flag. A set arriving in the same cycle as a clear wins.
- R2: In every cycle with `bus_grant_i` high, exactly one needing channel is served, the lowest-numbered one. In the next cycle `ack_o` is one-hot for it. With no served unit, `ack_o` and `mem_addr_o` are 0.
- R3: A channel programmed with count N moves N+1 units. The count falls by one per unit and wraps to all ones after the unit taken at zero when auto-initialise is off.
- R4: On a byte-wide controller (`WIDE16`=0), `mem_addr_o` is {page[7:0], address[15:0]}. The address wraps from FFFF to 0000 without touching the page.
- R5: On a word-wide controller (`WIDE16`=1), `mem_addr_o` is {page[7:1], address[15:0], 1'b0}, so each unit spans two bytes and the address wraps inside a 128 KiB page.
- R6: Mode bit 3 set makes the address fall by one per unit. Clear makes it rise by one.
- R7: The unit taken at count zero sets that channel's `tc_o` bit and clears its pending and request flags. `tc_clr_i` clears all `tc_o` bits, and a same-cycle set wins.
- R8: With mode bit 2 set, reaching terminal count reloads the current address and count from the values last programmed.
- R9: Mode bits [1:0] select the unit type: 01 strobes with `mem_wr_o`=1 (into memory), 10 strobes with `mem_wr_o`=0 (out of memory), and 00 verifies. A verify unit gives `ack_o` and an address, steps the count, and never strobes.
- R10: Type 11 is illegal. Serving it clears pending and request and gives no ack and no strobe, and the address and count stay unchanged.
- R11: While `ctrl_dis_i` is high, no channel is served and `dreq_i` sets no pending flag. `sw_req_i` is still recorded.
- R12: With `IS_SECONDARY`=1, channels are served only while `cascade_en_i` is high.
- R13: `temp_o` takes `data_i` at the clock edge that ends each strobe cycle.
- R14: `cfg_we_i` loads the address, count, page and mode of channel `cfg_ch_i` into both the working and the reload copy. `rd_addr_o` and `rd_count_o` show the working address and count of channel `rd_ch_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_grant_i | input | 1 | Bus granted to the sequencer for this cycle |
| ctrl_dis_i | input | 1 | Controller disabled |
| cascade_en_i | input | 1 | Primary cascade channel is in cascade mode |
| dreq_i | input | N_CH | Device request pulses |
| sw_req_i | input | N_CH | Software request pulses |
| mask_i | input | N_CH | Per-channel mask of device requests |
| tc_clr_i | input | 1 | Clear all terminal-count flags |
| cfg_we_i | input | 1 | Load channel registers |
| cfg_ch_i | input | CW | Channel to load |
| cfg_addr_i | input | AW | Start address |
| cfg_count_i | input | AW | Count (units minus one) |
| cfg_page_i | input | PW | Page bits |
| cfg_mode_i | input | 4 | {decrement, auto-init, type[1:0]} |
| data_i | input | DW | Data byte on the bus during a strobe |
| rd_ch_i | input | CW | Channel selected for readback |
| mem_addr_o | output | PW+AW | Physical address of the unit |
| mem_stb_o | output | 1 | Memory strobe |
| mem_wr_o | output | 1 | 1 = write into memory, 0 = read from memory |
| ack_o | output | N_CH | Channel served, one-hot |
| tc_o | output | N_CH | Terminal-count flags |
| pend_o | output | N_CH | Pending flags |
| req_o | output | N_CH | Software request flags |
| temp_o | output | DW | Last data byte moved |
| rd_addr_o | output | AW | Working address of `rd_ch_i` |
| rd_count_o | output | AW | Working count of `rd_ch_i` |

## Verification
The assertions check several rules on every cycle. `ack_o` stays one-hot or idle, and no channel is served while a lower-numbered one needed service. A strobe always carries an ack, and a write always carries a strobe. Nothing is served in the cycle after a disable or, on a secondary controller, after the cascade enable was low. A terminal-count flag only rises on an ack of its own channel, and a pending flag only rises after an enabled device request. Some properties only the scenarios can show: the exact address sequence across the 64 KiB and 128 KiB page wraps, the unit count of count+1, decrement with auto-initialise reload, verify without strobes, the illegal type dropping its requests, and the temporary register capturing the bus byte. The bench checks these against a cycle model of the two instances.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

  localparam int MODE_W    = 4;
  localparam int MODE_AUTO = 2;
  localparam int MODE_DEC  = 3;

  typedef enum logic [1:0] {
    XF_VERIFY   = 2'b00,
    XF_TO_MEM   = 2'b01,
    XF_FROM_MEM = 2'b10,
    XF_BAD      = 2'b11
  } xfer_e;

  function automatic xfer_e mode_xfer(input logic [MODE_W-1:0] m);
    return xfer_e'(m[1:0]);
  endfunction

endpackage

// File: rtl/dma_chan_state.sv
module dma_chan_state
  import dma_seq_pkg::*;
#(
  parameter int AW = 16,
  parameter int PW = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [AW-1:0]     count_i,
  input  logic [PW-1:0]     page_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              dreq_i,
  input  logic              dreq_ok_i,
  input  logic              sw_req_i,
  input  logic              tc_clr_i,
  input  logic              step_i,
  input  logic              drop_i,
  output logic [AW-1:0]     cur_addr_o,
  output logic [AW-1:0]     cur_count_o,
  output logic [PW-1:0]     page_o,
  output logic [MODE_W-1:0] mode_o,
  output logic              pend_o,
  output logic              req_o,
  output logic              tc_o
);

  logic [AW-1:0] base_addr_q, base_count_q;
  logic          last_w, fin_w, clr_w;

  assign last_w = (cur_count_o == '0);
  assign fin_w  = step_i && last_w;
  assign clr_w  = fin_w || drop_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_addr_q  <= '0;
      base_count_q <= '0;
      cur_addr_o   <= '0;
      cur_count_o  <= '0;
      page_o       <= '0;
      mode_o       <= '0;
    end else if (load_i) begin
      base_addr_q  <= addr_i;
      base_count_q <= count_i;
      cur_addr_o   <= addr_i;
      cur_count_o  <= count_i;
      page_o       <= page_i;
      mode_o       <= mode_i;
    end else if (step_i) begin
      if (last_w && mode_o[MODE_AUTO]) begin
        cur_addr_o  <= base_addr_q;
        cur_count_o <= base_count_q;
      end else begin
        cur_addr_o  <= mode_o[MODE_DEC] ? cur_addr_o - 1'b1 : cur_addr_o + 1'b1;
        cur_count_o <= cur_count_o - 1'b1;
      end
    end
  end

  // new requests win over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_o <= 1'b0;
      req_o  <= 1'b0;
      tc_o   <= 1'b0;
    end else begin
      pend_o <= (pend_o && !clr_w) || (dreq_i && dreq_ok_i);
      req_o  <= (req_o && !clr_w) || sw_req_i;
      tc_o   <= (tc_o && !tc_clr_i) || fin_w;
    end
  end

endmodule

// File: rtl/dma_prio_pick.sv
module dma_prio_pick #(
  parameter int N  = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  need_i,
  output logic [N-1:0]  sel_oh_o,
  output logic [IW-1:0] sel_idx_o,
  output logic          any_o
);

  // lowest index wins
  always_comb begin
    sel_oh_o  = '0;
    sel_idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (need_i[i]) begin
        sel_oh_o  = '0;
        sel_oh_o[i] = 1'b1;
        sel_idx_o = IW'(i);
      end
    end
  end

  assign any_o = |need_i;

endmodule

// File: rtl/dma_addr_form.sv
module dma_addr_form #(
  parameter int  AW     = 16,
  parameter int  PW     = 8,
  parameter bit  WIDE16 = 1'b0,
  localparam int OW     = PW + AW
) (
  input  logic [PW-1:0] page_i,
  input  logic [AW-1:0] addr_i,
  output logic [OW-1:0] phys_o
);

  generate
    if (WIDE16) begin : g_word
      // lowest page bit is replaced by the shifted address top bit
      assign phys_o = ({page_i, {AW{1'b0}}} & ~(OW'(1) << AW)) | (OW'(addr_i) << 1);
    end else begin : g_byte
      assign phys_o = {page_i, addr_i};
    end
  endgenerate

endmodule

// File: rtl/dma_xfer_seq.sv
module dma_xfer_seq
  import dma_seq_pkg::*;
#(
  parameter int  N_CH         = 4,
  parameter int  AW           = 16,
  parameter int  PW           = 8,
  parameter int  DW           = 8,
  parameter bit  WIDE16       = 1'b0,
  parameter bit  IS_SECONDARY = 1'b0,
  localparam int CW           = (N_CH > 1) ? $clog2(N_CH) : 1,
  localparam int OW           = PW + AW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_grant_i,
  input  logic              ctrl_dis_i,
  input  logic              cascade_en_i,
  input  logic [N_CH-1:0]   dreq_i,
  input  logic [N_CH-1:0]   sw_req_i,
  input  logic [N_CH-1:0]   mask_i,
  input  logic              tc_clr_i,
  input  logic              cfg_we_i,
  input  logic [CW-1:0]     cfg_ch_i,
  input  logic [AW-1:0]     cfg_addr_i,
  input  logic [AW-1:0]     cfg_count_i,
  input  logic [PW-1:0]     cfg_page_i,
  input  logic [MODE_W-1:0] cfg_mode_i,
  input  logic [DW-1:0]     data_i,
  input  logic [CW-1:0]     rd_ch_i,
  output logic [OW-1:0]     mem_addr_o,
  output logic              mem_stb_o,
  output logic              mem_wr_o,
  output logic [N_CH-1:0]   ack_o,
  output logic [N_CH-1:0]   tc_o,
  output logic [N_CH-1:0]   pend_o,
  output logic [N_CH-1:0]   req_o,
  output logic [DW-1:0]     temp_o,
  output logic [AW-1:0]     rd_addr_o,
  output logic [AW-1:0]     rd_count_o
);

  logic [AW-1:0]     cur_addr  [N_CH];
  logic [AW-1:0]     cur_count [N_CH];
  logic [PW-1:0]     page      [N_CH];
  logic [MODE_W-1:0] mode      [N_CH];

  logic [N_CH-1:0] need_w, sel_oh_w, step_w, drop_w;
  logic [CW-1:0]   sel_idx_w;
  logic            any_w, go_w, serve_en_w, dreq_ok_w;
  xfer_e           sel_xf_w;
  logic [OW-1:0]   phys_w;

  assign dreq_ok_w  = !ctrl_dis_i;
  assign serve_en_w = !ctrl_dis_i && (!IS_SECONDARY || cascade_en_i);

  generate
    for (genvar c = 0; c < N_CH; c++) begin : g_ch
      dma_chan_state #(.AW(AW), .PW(PW)) u_state (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .load_i      (cfg_we_i && (cfg_ch_i == CW'(c))),
        .addr_i      (cfg_addr_i),
        .count_i     (cfg_count_i),
        .page_i      (cfg_page_i),
        .mode_i      (cfg_mode_i),
        .dreq_i      (dreq_i[c]),
        .dreq_ok_i   (dreq_ok_w),
        .sw_req_i    (sw_req_i[c]),
        .tc_clr_i    (tc_clr_i),
        .step_i      (step_w[c]),
        .drop_i      (drop_w[c]),
        .cur_addr_o  (cur_addr[c]),
        .cur_count_o (cur_count[c]),
        .page_o      (page[c]),
        .mode_o      (mode[c]),
        .pend_o      (pend_o[c]),
        .req_o       (req_o[c]),
        .tc_o        (tc_o[c])
      );

      assign need_w[c] = serve_en_w && (req_o[c] || (pend_o[c] && !mask_i[c]));
      assign step_w[c] = go_w && sel_oh_w[c] && (sel_xf_w != XF_BAD);
      assign drop_w[c] = go_w && sel_oh_w[c] && (sel_xf_w == XF_BAD);
    end
  endgenerate

  dma_prio_pick #(.N(N_CH)) u_pick (
    .need_i    (need_w),
    .sel_oh_o  (sel_oh_w),
    .sel_idx_o (sel_idx_w),
    .any_o     (any_w)
  );

  assign go_w     = bus_grant_i && any_w;
  assign sel_xf_w = mode_xfer(mode[sel_idx_w]);

  dma_addr_form #(.AW(AW), .PW(PW), .WIDE16(WIDE16)) u_form (
    .page_i (page[sel_idx_w]),
    .addr_i (cur_addr[sel_idx_w]),
    .phys_o (phys_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_addr_o <= '0;
      mem_stb_o  <= 1'b0;
      mem_wr_o   <= 1'b0;
      ack_o      <= '0;
    end else begin
      mem_addr_o <= (go_w && sel_xf_w != XF_BAD) ? phys_w : '0;
      mem_stb_o  <= go_w && (sel_xf_w == XF_TO_MEM || sel_xf_w == XF_FROM_MEM);
      mem_wr_o   <= go_w && (sel_xf_w == XF_TO_MEM);
      ack_o      <= step_w;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) temp_o <= '0;
    else if (mem_stb_o) temp_o <= data_i;
  end

  assign rd_addr_o  = cur_addr[rd_ch_i];
  assign rd_count_o = cur_count[rd_ch_i];

endmodule

// File: rtl/dma_xfer_seq_chk.sv
module dma_xfer_seq_chk #(
  parameter int N_CH         = 4,
  parameter bit IS_SECONDARY = 1'b0
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            ctrl_dis_i,
  input logic            cascade_en_i,
  input logic [N_CH-1:0] dreq_i,
  input logic [N_CH-1:0] need_i,
  input logic [N_CH-1:0] ack_o,
  input logic [N_CH-1:0] tc_o,
  input logic [N_CH-1:0] pend_o,
  input logic            mem_stb_o,
  input logic            mem_wr_o
);

  assert_ack_onehot_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ack_o));

  assert_wr_needs_stb_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_o |-> mem_stb_o);

  assert_stb_has_ack_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_stb_o |-> (ack_o != '0));

  assert_idle_when_off_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(ctrl_dis_i) |-> (ack_o == '0 && !mem_stb_o));

  generate
    if (IS_SECONDARY) begin : g_sec
      assert_cascade_gate_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$past(cascade_en_i) |-> (ack_o == '0 && !mem_stb_o));
    end

    for (genvar k = 0; k < N_CH; k++) begin : g_k
      assert_tc_on_own_ack_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(tc_o[k]) |-> ack_o[k]);

      assert_pend_from_dreq_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(pend_o[k]) |-> $past(dreq_i[k] && !ctrl_dis_i));

      if (k > 0) begin : g_pri
        localparam logic [N_CH-1:0] LOWER = N_CH'((1 << k) - 1);
        assert_fixed_priority_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
          ack_o[k] |-> (($past(need_i) & LOWER) == '0));
      end
    end
  endgenerate

endmodule

bind dma_xfer_seq dma_xfer_seq_chk #(.N_CH(N_CH), .IS_SECONDARY(IS_SECONDARY)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .ctrl_dis_i   (ctrl_dis_i),
  .cascade_en_i (cascade_en_i),
  .dreq_i       (dreq_i),
  .need_i       (need_w),
  .ack_o        (ack_o),
  .tc_o         (tc_o),
  .pend_o       (pend_o),
  .mem_stb_o    (mem_stb_o),
  .mem_wr_o     (mem_wr_o)
);

// File: tb/dma_xfer_seq_bench.sv
`timescale 1ns/1ps
module dma_xfer_seq_bench;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        grant = 0, dis = 0, casc = 1, tc_clr = 0, cfg_we = 0;
  logic [3:0]  dreq = 0, sw = 0, mask = 0, cfg_mode = 0;
  logic [1:0]  cfg_ch = 0, rd_ch = 0;
  logic [15:0] cfg_addr = 0, cfg_count = 0;
  logic [7:0]  cfg_page = 0, data = 0;

  logic [23:0] o_addr [2];
  logic        o_stb [2], o_wr [2];
  logic [3:0]  o_ack [2], o_tc [2], o_pend [2], o_req [2];
  logic [7:0]  o_temp [2];
  logic [15:0] o_rda [2], o_rdc [2];

  dma_xfer_seq u_dma_xfer_seq (
    .clk_i(clk), .rst_ni(rst_n), .bus_grant_i(grant), .ctrl_dis_i(dis), .cascade_en_i(casc),
    .dreq_i(dreq), .sw_req_i(sw), .mask_i(mask), .tc_clr_i(tc_clr), .cfg_we_i(cfg_we),
    .cfg_ch_i(cfg_ch), .cfg_addr_i(cfg_addr), .cfg_count_i(cfg_count), .cfg_page_i(cfg_page),
    .cfg_mode_i(cfg_mode), .data_i(data), .rd_ch_i(rd_ch),
    .mem_addr_o(o_addr[0]), .mem_stb_o(o_stb[0]), .mem_wr_o(o_wr[0]), .ack_o(o_ack[0]),
    .tc_o(o_tc[0]), .pend_o(o_pend[0]), .req_o(o_req[0]), .temp_o(o_temp[0]),
    .rd_addr_o(o_rda[0]), .rd_count_o(o_rdc[0]));

  dma_xfer_seq #(.WIDE16(1'b1), .IS_SECONDARY(1'b1)) u_dma_xfer_seq_w16 (
    .clk_i(clk), .rst_ni(rst_n), .bus_grant_i(grant), .ctrl_dis_i(dis), .cascade_en_i(casc),
    .dreq_i(dreq), .sw_req_i(sw), .mask_i(mask), .tc_clr_i(tc_clr), .cfg_we_i(cfg_we),
    .cfg_ch_i(cfg_ch), .cfg_addr_i(cfg_addr), .cfg_count_i(cfg_count), .cfg_page_i(cfg_page),
    .cfg_mode_i(cfg_mode), .data_i(data), .rd_ch_i(rd_ch),
    .mem_addr_o(o_addr[1]), .mem_stb_o(o_stb[1]), .mem_wr_o(o_wr[1]), .ack_o(o_ack[1]),
    .tc_o(o_tc[1]), .pend_o(o_pend[1]), .req_o(o_req[1]), .temp_o(o_temp[1]),
    .rd_addr_o(o_rda[1]), .rd_count_o(o_rdc[1]));

  int checks = 0, errors = 0, cyc = 0;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  // ---------------- reference model ----------------
  logic [15:0] m_ba [2][4], m_bc [2][4], m_ca [2][4], m_cc [2][4];
  logic [7:0]  m_pg [2][4];
  logic [3:0]  m_md [2][4];
  logic [3:0]  m_pend [2], m_req [2], m_tc [2], m_ack [2];
  logic [23:0] m_addr [2];
  logic        m_stb [2], m_wr [2];
  logic [7:0]  m_temp [2];

  function automatic logic [23:0] form(input int n, input logic [7:0] p, input logic [15:0] a);
    if (n == 0) return {p, a};
    return {p[7:1], a, 1'b0};
  endfunction

  task automatic m_reset();
    for (int n = 0; n < 2; n++) begin
      for (int c = 0; c < 4; c++) begin
        m_ba[n][c] = 0; m_bc[n][c] = 0; m_ca[n][c] = 0; m_cc[n][c] = 0;
        m_pg[n][c] = 0; m_md[n][c] = 0;
      end
      m_pend[n] = 0; m_req[n] = 0; m_tc[n] = 0; m_ack[n] = 0;
      m_addr[n] = 0; m_stb[n] = 0; m_wr[n] = 0; m_temp[n] = 0;
    end
  endtask

  task automatic m_update();
    for (int n = 0; n < 2; n++) begin
      logic en, go, step, drop, fin, clr;
      logic [1:0] typ;
      int pk;
      en = !dis && (n == 0 || casc);
      pk = -1;
      for (int c = 3; c >= 0; c--)
        if (en && (m_req[n][c] || (m_pend[n][c] && !mask[c]))) pk = c;
      go  = grant && (pk >= 0);
      typ = go ? m_md[n][pk][1:0] : 2'b00;
      if (m_stb[n]) m_temp[n] = data;
      m_stb[n]  = go && (typ == 2'b01 || typ == 2'b10);
      m_wr[n]   = go && (typ == 2'b01);
      m_ack[n]  = (go && typ != 2'b11) ? 4'(1 << pk) : 4'h0;
      m_addr[n] = (go && typ != 2'b11) ? form(n, m_pg[n][pk], m_ca[n][pk]) : 24'h0;
      for (int c = 0; c < 4; c++) begin
        step = go && pk == c && typ != 2'b11;
        drop = go && pk == c && typ == 2'b11;
        fin  = step && m_cc[n][c] == 0;
        if (cfg_we && cfg_ch == 2'(c)) begin
          m_ba[n][c] = cfg_addr; m_ca[n][c] = cfg_addr;
          m_bc[n][c] = cfg_count; m_cc[n][c] = cfg_count;
          m_pg[n][c] = cfg_page; m_md[n][c] = cfg_mode;
        end else if (step) begin
          if (fin && m_md[n][c][2]) begin
            m_ca[n][c] = m_ba[n][c]; m_cc[n][c] = m_bc[n][c];
          end else begin
            m_ca[n][c] = m_md[n][c][3] ? m_ca[n][c] - 16'd1 : m_ca[n][c] + 16'd1;
            m_cc[n][c] = m_cc[n][c] - 16'd1;
          end
        end
        clr = fin || drop;
        m_pend[n][c] = (m_pend[n][c] && !clr) || (dreq[c] && !dis);
        m_req[n][c]  = (m_req[n][c] && !clr) || sw[c];
        m_tc[n][c]   = (m_tc[n][c] && !tc_clr) || fin;
      end
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (!rst_n) m_reset();
    else m_update();
  end

  // ---------------- per-cycle compare and monitor ----------------
  logic [23:0] sa0[$], sa1[$];
  logic [3:0]  sk0[$];
  int sc0 = 0;

  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      for (int n = 0; n < 2; n++) begin
        chk(n == 0 ? "R4 mem_addr" : "R5 mem_addr", o_addr[n], m_addr[n]);
        chk("R9 strobe", o_stb[n], m_stb[n]);
        chk("R9 direction", o_wr[n], m_wr[n]);
        chk("R2 ack", o_ack[n], m_ack[n]);
        chk("R7 tc", o_tc[n], m_tc[n]);
        chk("R1 pending", o_pend[n], m_pend[n]);
        chk("R1 request", o_req[n], m_req[n]);
        chk("R13 temp", o_temp[n], m_temp[n]);
        chk("R6 rd_addr", o_rda[n], m_ca[n][rd_ch]);
        chk("R3 rd_count", o_rdc[n], m_cc[n][rd_ch]);
      end
      if (o_ack[0] != 0) begin sa0.push_back(o_addr[0]); sk0.push_back(o_ack[0]); end
      if (o_ack[1] != 0) sa1.push_back(o_addr[1]);
      if (o_stb[0]) sc0++;
    end
  end

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog got %0d cycles exp completion", cyc);
      summary();
      $finish;
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic nxt();
    @(negedge clk);
    #2;
  endtask

  task automatic prog(input logic [1:0] ch, input logic [15:0] a, input logic [15:0] c,
                      input logic [7:0] p, input logic [3:0] m);
    cfg_we = 1; cfg_ch = ch; cfg_addr = a; cfg_count = c; cfg_page = p; cfg_mode = m;
    nxt();
    cfg_we = 0;
  endtask

  task automatic swr(input logic [3:0] v);
    sw = v; nxt(); sw = 0;
  endtask

  task automatic run(input int k);
    grant = 1;
    repeat (k) nxt();
    grant = 0;
    nxt();
  endtask

  task automatic clrq();
    sa0.delete(); sa1.delete(); sk0.delete(); sc0 = 0;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) nxt();
    chk("R2 reset ack", o_ack[0], 4'h0);
    chk("R7 reset tc", o_tc[0], 4'h0);
    chk("R1 reset pending", o_pend[1], 4'h0);
    chk("R9 reset strobe", o_stb[0], 1'b0);
    rst_n = 1;
    nxt();

    // wrap inside the page, both widths
    prog(2, 16'hFFFE, 16'd2, 8'h12, 4'h1);
    rd_ch = 2;
    #0.1;
    chk("R14 readback address", o_rda[0], 16'hFFFE);
    chk("R14 readback count", o_rdc[1], 16'd2);
    swr(4'b0100);
    clrq();
    run(5);
    chk("R3 unit count", sa0.size(), 3);
    if (sa0.size() == 3) begin
      chk("R4 first", sa0[0], 24'h12FFFE);
      chk("R4 wrap", sa0[2], 24'h120000);
    end
    if (sa1.size() == 3) begin
      chk("R5 first", sa1[0], 24'h13FFFC);
      chk("R5 second", sa1[1], 24'h13FFFE);
      chk("R5 wrap", sa1[2], 24'h120000);
    end else chk("R5 unit count", sa1.size(), 3);
    chk("R7 tc set", o_tc[0][2], 1'b1);
    chk("R7 request cleared", o_req[0][2], 1'b0);
    chk("R3 count after end", o_rdc[0], 16'hFFFF);
    tc_clr = 1; nxt(); tc_clr = 0;
    chk("R7 tc cleared", o_tc[0], 4'h0);

    // decrement with auto-initialise
    prog(1, 16'h0001, 16'd1, 8'h40, 4'hD);
    swr(4'b0010);
    clrq();
    run(4);
    chk("R6 unit count", sa0.size(), 2);
    if (sa0.size() == 2) begin
      chk("R6 first", sa0[0], 24'h400001);
      chk("R6 second", sa0[1], 24'h400000);
    end
    rd_ch = 1;
    nxt();
    chk("R8 address reloaded", o_rda[0], 16'h0001);
    chk("R8 count reloaded", o_rdc[0], 16'd1);
    chk("R9 write strobes", sc0, 2);

    // verify
    prog(3, 16'h0100, 16'd0, 8'h00, 4'h0);
    swr(4'b1000);
    clrq();
    run(3);
    chk("R9 verify ack", sk0.size(), 1);
    chk("R9 verify no strobe", sc0, 0);
    chk("R7 verify tc", o_tc[0][3], 1'b1);

    // illegal type
    prog(0, 16'h0200, 16'd3, 8'h00, 4'h3);
    swr(4'b0001);
    clrq();
    run(3);
    rd_ch = 0;
    nxt();
    chk("R10 no ack", sk0.size(), 0);
    chk("R10 request dropped", o_req[0][0], 1'b0);
    chk("R10 count unchanged", o_rdc[0], 16'd3);

    // disabled controller
    dis = 1;
    dreq = 4'b0001; nxt(); dreq = 0;
    sw = 4'b0001; nxt(); sw = 0;
    clrq();
    grant = 1; nxt(); nxt(); grant = 0;
    nxt();
    chk("R11 no pending", o_pend[0][0], 1'b0);
    chk("R11 sw recorded", o_req[0][0], 1'b1);
    chk("R11 no service", sk0.size(), 0);
    dis = 0;
    run(2);

    // cascade gate on the secondary instance
    prog(2, 16'h0000, 16'd1, 8'h00, 4'h2);
    casc = 0;
    swr(4'b0100);
    clrq();
    run(4);
    chk("R12 primary served", sa0.size(), 2);
    chk("R12 secondary held", sa1.size(), 0);
    casc = 1;
    clrq();
    run(4);
    chk("R12 secondary served", sa1.size(), 2);

    // priority and masking
    prog(1, 16'h0010, 16'd0, 8'h00, 4'h1);
    prog(3, 16'h0030, 16'd0, 8'h00, 4'h1);
    swr(4'b1010);
    clrq();
    run(4);
    chk("R2 count", sk0.size(), 2);
    if (sk0.size() == 2) begin
      chk("R2 first channel", sk0[0], 4'b0010);
      chk("R2 second channel", sk0[1], 4'b1000);
    end
    prog(3, 16'h0030, 16'd0, 8'h00, 4'h1);
    mask = 4'b1000;
    dreq = 4'b1000; nxt(); dreq = 0;
    clrq();
    run(2);
    chk("R1 masked", sk0.size(), 0);
    chk("R1 pending kept", o_pend[0][3], 1'b1);
    mask = 0;
    run(2);
    chk("R1 unmasked", sk0.size(), 1);

    // temporary register
    prog(1, 16'h0010, 16'd1, 8'h00, 4'h1);
    data = 8'hA5;
    swr(4'b0010);
    run(4);
    chk("R13 temp primary", o_temp[0], 8'hA5);
    chk("R13 temp secondary", o_temp[1], 8'hA5);

    // constrained random
    for (int i = 0; i < 4000; i++) begin
      grant  = ($urandom % 4) != 0;
      dreq   = (($urandom % 8) == 0) ? 4'($urandom) : 4'h0;
      sw     = (($urandom % 16) == 0) ? 4'($urandom) : 4'h0;
      if (($urandom % 32) == 0) mask = 4'($urandom);
      dis    = ($urandom % 20) == 0;
      casc   = ($urandom % 10) != 0;
      tc_clr = ($urandom % 16) == 0;
      data   = 8'($urandom);
      rd_ch  = 2'($urandom);
      cfg_we = ($urandom % 12) == 0;
      cfg_ch = 2'($urandom);
      cfg_count = 16'($urandom % 6);
      cfg_page  = 8'($urandom);
      cfg_mode  = 4'($urandom);
      case ($urandom % 3)
        0: cfg_addr = 16'hFFFF - 16'($urandom % 3);
        1: cfg_addr = 16'($urandom % 3);
        default: cfg_addr = 16'($urandom);
      endcase
      nxt();
    end
    grant = 0; dreq = 0; sw = 0; cfg_we = 0; tc_clr = 0; dis = 0;
    nxt();
    nxt();
    summary();
    $finish;
  end

endmodule